// File: doc/BRIEF.md
# Rotating Warp Selector with Lockout Mask

This block decides, once per clock, which warp of a multi-warp core is sent next to instruction fetch. A warp qualifies when its active flag is high and its lockout bit is low. The search begins at the warp just after the one most recently handed to fetch, wraps around, and looks at each warp once. The first qualifying warp found is offered on a valid/ready handshake. When fetch accepts it, that warp becomes the new search origin and its lockout bit is set, so it cannot be offered again while its instruction is in flight.

The lockout bit is released by one of two later events. For an ordinary instruction, the decode stage reports the warp and the bit clears. For an instruction flagged as holding the warp, such as a branch, the decode report leaves the bit set. The bit then clears only when the execution side reports that the instruction has completed.

The controller has two states. `ST_IDLE` means nothing is offered. `ST_OFFER` means a warp index is presented with valid high. Transitions: `ST_IDLE -> ST_OFFER` when the search finds a qualifying warp. `ST_OFFER -> ST_OFFER` when the offer is held under backpressure, or when it is accepted and a further warp qualifies. `ST_OFFER -> ST_IDLE` when the offer is accepted and no further warp qualifies. `ST_IDLE -> ST_IDLE` when no warp qualifies. The search result is registered, so an offer appears on the clock edge after the warp becomes eligible.

Top module: `warp_sched_rr`

## Requirements
- R1: After reset, all lockout bits are clear, no offer is made (`fetch_valid_o` low), and the search origin is the last warp, so warp 0 is examined first.
- R2: The search starts at the warp after the last accepted one, continues upward, and wraps from the highest index to warp 0.
- R3: Only a warp whose bit in `warp_active_i` is 1 and whose lockout bit is 0 is ever offered.
- R4: Acceptance (`fetch_valid_o` and `fetch_ready_i` high at a clock edge) sets the accepted warp's lockout bit. That warp is not offered again until the bit is cleared.
- R5: A decode report (`dec_valid_i` = 1, `dec_hold_i` = 0) clears the lockout bit of warp `dec_wid_i`.
- R6: A decode report with `dec_hold_i` = 1 leaves the lockout bit set. A completion report (`exe_valid_i` = 1) clears the lockout bit of warp `exe_wid_i`.
- R7: When no warp qualifies, `fetch_valid_o` stays low and the search origin does not change.
- R8: While an offer is not accepted, `fetch_valid_o` stays high and `fetch_wid_o` stays unchanged. Neither the origin nor any lockout bit is updated by the offer.
- R9: If a clear and an acceptance target the same warp in the same cycle, the clear is applied first and the set second, so the warp ends up locked out.
- R10: At most one warp is accepted per cycle. An offer appears on the clock edge after its warp becomes eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| warp_active_i | input | NUM_WARPS | Per-warp active flags |
| fetch_valid_o | output | 1 | A warp index is offered to fetch |
| fetch_ready_i | input | 1 | Fetch accepts the offered warp |
| fetch_wid_o | output | WID_W | Offered warp index |
| dec_valid_i | input | 1 | Decode stage reports a warp's instruction |
| dec_wid_i | input | WID_W | Warp index of the decode report |
| dec_hold_i | input | 1 | The reported instruction keeps the warp locked out |
| exe_valid_i | input | 1 | Execution side reports a holding instruction completed |
| exe_wid_i | input | WID_W | Warp index of the completion report |

## Verification
On every cycle, the assertions check four things: an offered warp is never locked out; a held offer keeps its index; an accepted warp is locked out on the next cycle; and the search origin moves only on acceptance. They also check that the search never returns an ineligible warp. The bench scenarios cover what a single cycle cannot show. These are the rotation order with wrap-around, skipping of inactive warps, the origin surviving an idle stretch, the two different release paths, and a same-cycle clear and set leaving the warp locked out.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } offer_state_e;
endpackage

// File: rtl/wsched_lockout.sv
module wsched_lockout #(
    parameter int NUM_WARPS = 8,
    parameter int WID_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [WID_W-1:0]     set_wid,
    input  logic                 clr_a_en,
    input  logic [WID_W-1:0]     clr_a_wid,
    input  logic                 clr_b_en,
    input  logic [WID_W-1:0]     clr_b_wid,
    output logic [NUM_WARPS-1:0] lock_q,
    output logic [NUM_WARPS-1:0] lock_d
);
    logic [NUM_WARPS-1:0] set_vec;
    logic [NUM_WARPS-1:0] clr_vec;

    for (genvar i = 0; i < NUM_WARPS; i++) begin : g_bit
        assign set_vec[i] = set_en   && (set_wid   == WID_W'(i));
        assign clr_vec[i] = (clr_a_en && (clr_a_wid == WID_W'(i)))
                         || (clr_b_en && (clr_b_wid == WID_W'(i)));
        // clear first, then set (set wins)
        assign lock_d[i]  = set_vec[i] | (lock_q[i] & ~clr_vec[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lock_q[i] <= 1'b0;
            else        lock_q[i] <= lock_d[i];
        end
    end

    // R5
    clr_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_a_en && !(set_en && set_wid == clr_a_wid)) |=> !lock_q[$past(clr_a_wid)]);
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> lock_q[$past(set_wid)]);
endmodule

// File: rtl/wsched_rr_pick.sv
module wsched_rr_pick #(
    parameter int NUM_WARPS = 8,
    parameter int WID_W     = 3
) (
    input  logic [NUM_WARPS-1:0] elig,
    input  logic [WID_W-1:0]     origin,
    output logic                 found,
    output logic [WID_W-1:0]     pick
);
    localparam logic [WID_W:0] N_EXT = (WID_W+1)'(NUM_WARPS);

    logic [WID_W-1:0]     cand [NUM_WARPS];
    logic [NUM_WARPS-1:0] hit;

    for (genvar k = 0; k < NUM_WARPS; k++) begin : g_slot
        logic [WID_W:0] sum;
        assign sum     = {1'b0, origin} + (WID_W+1)'(k + 1);
        assign cand[k] = (sum >= N_EXT) ? WID_W'(sum - N_EXT) : WID_W'(sum);
        assign hit[k]  = elig[cand[k]];
    end

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < NUM_WARPS; k++) begin
            if (!found && hit[k]) begin
                found = 1'b1;
                pick  = cand[k];
            end
        end
    end

    // R3
    pick_eligible_chk: assert final (!found || elig[pick]);
    // R7
    none_found_chk: assert final ((elig != '0) || !found);
endmodule

// File: rtl/warp_sched_rr.sv
module warp_sched_rr
    import wsched_pkg::*;
#(
    parameter int NUM_WARPS = 8,
    parameter int WID_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] warp_active_i,
    output logic                 fetch_valid_o,
    input  logic                 fetch_ready_i,
    output logic [WID_W-1:0]     fetch_wid_o,
    input  logic                 dec_valid_i,
    input  logic [WID_W-1:0]     dec_wid_i,
    input  logic                 dec_hold_i,
    input  logic                 exe_valid_i,
    input  logic [WID_W-1:0]     exe_wid_i
);
    localparam logic [WID_W-1:0] LAST_WID = WID_W'(NUM_WARPS - 1);

    offer_state_e         state_q, state_d;
    logic [WID_W-1:0]     wid_q, wid_d;
    logic [WID_W-1:0]     origin_q, origin_d;
    logic                 accept;
    logic [NUM_WARPS-1:0] lock_q, lock_d;
    logic [NUM_WARPS-1:0] elig;
    logic                 found;
    logic [WID_W-1:0]     pick;

    assign accept   = (state_q == ST_OFFER) && fetch_ready_i;
    assign origin_d = accept ? wid_q : origin_q;
    assign elig     = warp_active_i & ~lock_d;

    wsched_lockout #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (accept),
        .set_wid   (wid_q),
        .clr_a_en  (dec_valid_i && !dec_hold_i),
        .clr_a_wid (dec_wid_i),
        .clr_b_en  (exe_valid_i),
        .clr_b_wid (exe_wid_i),
        .lock_q    (lock_q),
        .lock_d    (lock_d)
    );

    wsched_rr_pick #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_pick (
        .elig   (elig),
        .origin (origin_d),
        .found  (found),
        .pick   (pick)
    );

    // next-state process
    always_comb begin
        state_d = state_q;
        wid_d   = wid_q;
        unique case (state_q)
            ST_IDLE: begin
                if (found) begin
                    state_d = ST_OFFER;
                    wid_d   = pick;
                end
            end
            ST_OFFER: begin
                if (fetch_ready_i) begin
                    if (found) begin
                        state_d = ST_OFFER;
                        wid_d   = pick;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            wid_q    <= '0;
            origin_q <= LAST_WID;
        end else begin
            state_q  <= state_d;
            wid_q    <= wid_d;
            origin_q <= origin_d;
        end
    end

    // output process
    always_comb begin
        fetch_valid_o = (state_q == ST_OFFER);
        fetch_wid_o   = wid_q;
    end

    // R3
    offer_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_o |-> !lock_q[fetch_wid_o]);
    // R8
    offer_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_o && !fetch_ready_i) |=> (fetch_valid_o && $stable(fetch_wid_o)));
    // R4
    accept_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_o && fetch_ready_i) |=> lock_q[$past(fetch_wid_o)]);
    // R7
    origin_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_valid_o && fetch_ready_i) |=> $stable(origin_q));
endmodule

// File: tb/warp_sched_rr_test.sv
module warp_sched_rr_test;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] active = '0;
    logic          fvalid;
    logic          fready = 1'b0;
    logic [IW-1:0] fwid;
    logic          dvalid = 1'b0;
    logic [IW-1:0] dwid = '0;
    logic          dhold = 1'b0;
    logic          evalid = 1'b0;
    logic [IW-1:0] ewid = '0;

    int total = 0;
    int bad = 0;
    int expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    warp_sched_rr #(.NUM_WARPS(NW)) uut (
        .clk(clk), .rst_n(rst_n), .warp_active_i(active),
        .fetch_valid_o(fvalid), .fetch_ready_i(fready), .fetch_wid_o(fwid),
        .dec_valid_i(dvalid), .dec_wid_i(dwid), .dec_hold_i(dhold),
        .exe_valid_i(evalid), .exe_wid_i(ewid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops expected warp at every handshake (R2 R3 R4)
    always @(negedge clk) begin
        if (rst_n && fvalid && fready) begin
            if (expq.size() == 0) begin
                check(0, "R4 R9 unexpected accept", int'(fwid), -1);
            end else begin
                int e;
                e = expq.pop_front();
                check(int'(fwid) == e, "R2 R3 accepted warp", int'(fwid), e);
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic drain(input string req);
        int guard = 0;
        while (expq.size() != 0 && guard < 100) begin
            step(1);
            guard++;
        end
        check(expq.size() == 0, req, expq.size(), 0);
        expq.delete();
    endtask

    task automatic idle_check(input string req);
        step(3);
        @(negedge clk);
        check(!fvalid, req, int'(fvalid), 0);
        step(1);
    endtask

    task automatic exe_clear(input int w);
        evalid = 1'b1; ewid = IW'(w);
        step(1);
        evalid = 1'b0;
    endtask

    task automatic dec_report(input int w, input bit hold);
        dvalid = 1'b1; dwid = IW'(w); dhold = hold;
        step(1);
        dvalid = 1'b0; dhold = 1'b0;
    endtask

    initial begin
        int held;
        step(2);
        rst_n = 1'b1;
        fready = 1'b1;
        idle_check("R1 no offer after reset");

        // R1 R2: warp 0 first, then rotation; R10 one per cycle
        expq.push_back(0); expq.push_back(1); expq.push_back(2); expq.push_back(3);
        active = 4'b1111;
        drain("R1 R10 rotation drained");
        idle_check("R4 all locked out");

        // R5: plain decode report releases warp 2
        expq.push_back(2);
        dec_report(2, 1'b0);
        drain("R5 release by decode");
        idle_check("R4 relocked after R5");

        // R6: holding report keeps warp 1 locked until completion
        dec_report(1, 1'b1);
        idle_check("R6 hold keeps lockout");
        expq.push_back(1);
        exe_clear(1);
        drain("R6 release by completion");

        // R7: idle stretch keeps origin at 1; R3 skips inactive; R2 wraps
        active = '0;
        for (int w = 0; w < NW; w++) exe_clear(w);
        idle_check("R7 nothing eligible");
        expq.push_back(3); expq.push_back(1);
        active = 4'b1010;
        drain("R2 R3 R7 order 3 then 1");
        idle_check("R4 locked after wrap");

        // R8: backpressure holds offer
        active = '0;
        fready = 1'b0;
        for (int w = 0; w < NW; w++) exe_clear(w);
        active = 4'b0100;
        step(2);
        @(negedge clk);
        held = int'(fwid);
        check(fvalid && held == 2, "R8 offer presented", held, 2);
        for (int i = 0; i < 3; i++) begin
            step(1);
            @(negedge clk);
            check(fvalid && int'(fwid) == held, "R8 offer stable", int'(fwid), held);
        end

        // R9: clear and accept for warp 2 in the same cycle
        step(1);
        expq.push_back(2);
        fready = 1'b1;
        dec_report(2, 1'b0);
        drain("R9 accepted");
        idle_check("R9 set wins over clear");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule